// File: doc/BRIEF.md
# SPI Register Access Frame Controller

This block is the serial front end of a system controller's register file. An SPI master opens an access by pulling the active-low chip select, clocks exactly sixteen bits in most-significant-bit first, and closes the access by releasing chip select. The first four bits are a header: a two-bit register address, a bit that chooses between two readback registers, and a flag that makes the access read-only. The remaining twelve bits are write data. While the header and data shift in, the block shifts a reply word out. The reply starts with a four-bit echo of the current operating mode. It then carries the twelve-bit register that the header selected.

The meaning of each address depends on the operating mode, which the block receives on an input. Only a complete sixteen-clock access changes anything. An access with any other clock count is discarded. It raises either a maskable failure interrupt or a system reset request, depending on the mode. A write to the mode register also counts as a watchdog service and emits a one-cycle pulse. If that write carries an undefined mode code or an undefined watchdog-period code, the block requests a reset instead of storing it.

All serial inputs are oversampled by the system clock through synchronizers. SCLK must stay slow enough that each level lasts at least four system clock cycles.

Top module: `spi_frame_ctl`

## Requirements
- R1: During and after synchronous reset, every stored register reads 0, `miso` is 0, and `wd_serve`, `spi_fail_irq` and `rst_req` stay low until a frame ends.
- R2: A frame word is sent MSB first and sampled on rising SCLK. Bits 15:14 are the address, bit 13 is the readback select, bit 12 is the read-only flag and bits 11:0 are the data. With the read-only flag at 0, the data is written when chip select rises after exactly 16 rising edges.
- R3: With the read-only flag at 1, no register is written and no watchdog pulse is produced, but the reply still carries the selected register.
- R4: A frame with any number of rising SCLK edges other than 16 (including 0 and 17) changes no register.
- R5: A failed frame in operating mode 2 (normal), 3 (standby) or 4 (flash) gives a one-cycle `spi_fail_irq` pulse only when bit 0 of the interrupt-enable register is 1, and never a reset request.
- R6: A failed frame in operating mode 0 (start-up) or 1 (restart) gives a one-cycle `rst_req` pulse and no interrupt.
- R7: In modes 2 and 3, addresses 1, 2 and 3 write the interrupt-enable, system-configuration and physical-layer registers. In all other modes they write the special-mode register and general-purpose registers 0 and 1.
- R8: For address 0 the reply data is `sys_status` when the select bit is 0 and `sys_diag` when it is 1.
- R9: For addresses 1 to 3 with the select bit at 0, the reply is the interrupt-enable, system-configuration or physical-layer register. With the select bit at 1, it is `irq_flags` (address 1 in modes 2 and 3), the special-mode register (address 1 in other modes), or general-purpose register 0 or 1 (addresses 2 and 3).
- R10: The first four reply bits are 0 followed by the 3-bit operating mode. The twelve data bits follow MSB first, and each new bit is driven after a falling SCLK edge.
- R11: A write to address 0 whose bits 2:0 are below 5 and whose bits 6:3 are below 12 stores the word in the mode register and gives exactly one `wd_serve` pulse.
- R12: A write to address 0 with bits 2:0 of 5 to 7 or bits 6:3 of 12 to 15 leaves the mode register unchanged, gives no `wd_serve`, and gives one `rst_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle low |
| csn | input | 1 | Active-low chip select framing one access |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial reply to master |
| op_mode | input | 3 | Current operating mode: 0 start-up, 1 restart, 2 normal, 3 standby, 4 flash |
| sys_status | input | 12 | System status word for readback |
| sys_diag | input | 12 | System diagnosis word for readback |
| irq_flags | input | 12 | Pending interrupt flags for readback |
| mode_q | output | 12 | Mode register |
| int_en_q | output | 12 | Interrupt-enable register |
| sys_cfg_q | output | 12 | System-configuration register |
| phy_q | output | 12 | Physical-layer control register |
| special_q | output | 12 | Special-mode register |
| gp0_q | output | 12 | General-purpose register 0 |
| gp1_q | output | 12 | General-purpose register 1 |
| wd_serve | output | 1 | One-cycle watchdog service pulse |
| spi_fail_irq | output | 1 | One-cycle SPI failure interrupt pulse |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The hardest states to reach are the register banks that only the less common modes can write, and the failure paths that must leave them untouched. The stimulus first fills the application-side registers in normal mode. It then switches the mode input to flash, fills the alternate registers, and reads each one back through the other select bit. Frames of 0, 15 and 17 clocks are then sent under both mode classes and with the interrupt enable both set and cleared. After each of these frames, the registers the frame addressed are compared against their earlier values.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int HDR_W = 4;
  localparam int OPM_W = 3;

  typedef enum logic [OPM_W-1:0] {
    OPM_STARTUP = 3'd0,
    OPM_RESTART = 3'd1,
    OPM_NORMAL  = 3'd2,
    OPM_STANDBY = 3'd3,
    OPM_FLASH   = 3'd4
  } opmode_e;

  // Modes in which the application register bank is mapped
  function automatic logic is_app_mode(input logic [OPM_W-1:0] m);
    return (m == OPM_NORMAL) || (m == OPM_STANDBY);
  endfunction

  // Modes in which a framing error forces a reset
  function automatic logic is_boot_mode(input logic [OPM_W-1:0] m);
    return (m == OPM_STARTUP) || (m == OPM_RESTART);
  endfunction
endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [OPM_W-1:0]  op_mode,
  input  logic [DATA_W-1:0] rd_data,
  output logic [1:0]        hdr_addr,
  output logic              hdr_rrs,
  output logic              frame_end,
  output logic              frame_ok,
  output logic [1:0]        frame_addr,
  output logic              frame_ro,
  output logic [DATA_W-1:0] frame_data,
  output logic              miso
);
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);

  logic               sclk_d, csn_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] rx_sr, tx_sr;
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d & ~csn_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~csn_s;
  assign cs_fall   = ~csn_s & csn_d;
  assign cs_rise   = csn_s & ~csn_d;

  // Header as it stands once the fourth bit is being sampled
  assign hdr_addr = rx_sr[2:1];
  assign hdr_rrs  = rx_sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      csn_d      <= 1'b1;
      cnt        <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      miso       <= 1'b0;
      frame_end  <= 1'b0;
      frame_ok   <= 1'b0;
      frame_addr <= '0;
      frame_ro   <= 1'b0;
      frame_data <= '0;
    end else begin
      sclk_d    <= sclk_s;
      csn_d     <= csn_s;
      frame_end <= 1'b0;
      if (cs_fall) begin
        cnt   <= '0;
        tx_sr <= {1'b0, op_mode, {DATA_W{1'b0}}};
        miso  <= 1'b0;
      end else if (sclk_rise) begin
        rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        if (cnt == CNT_HDR) tx_sr[FRAME_W-2 -: DATA_W] <= rd_data;
      end else if (sclk_fall) begin
        tx_sr <= tx_sr << 1;
        miso  <= tx_sr[FRAME_W-2];
      end
      if (cs_rise) begin
        frame_end  <= 1'b1;
        frame_ok   <= (cnt == CNT_FULL);
        frame_addr <= rx_sr[FRAME_W-1 -: 2];
        frame_ro   <= rx_sr[DATA_W];
        frame_data <= rx_sr[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_frame_regs.sv
module spi_frame_regs
  import spi_frame_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int MODE_CODES = 5,
  parameter int WD_CODES   = 12,
  parameter int IE_SPI_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPM_W-1:0]  op_mode,
  input  logic [1:0]        hdr_addr,
  input  logic              hdr_rrs,
  input  logic              frame_end,
  input  logic              frame_ok,
  input  logic [1:0]        frame_addr,
  input  logic              frame_ro,
  input  logic [DATA_W-1:0] frame_data,
  input  logic [DATA_W-1:0] sys_status,
  input  logic [DATA_W-1:0] sys_diag,
  input  logic [DATA_W-1:0] irq_flags,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] int_en_q,
  output logic [DATA_W-1:0] sys_cfg_q,
  output logic [DATA_W-1:0] phy_q,
  output logic [DATA_W-1:0] special_q,
  output logic [DATA_W-1:0] gp0_q,
  output logic [DATA_W-1:0] gp1_q,
  output logic              wd_serve,
  output logic              spi_fail_irq,
  output logic              rst_req
);
  localparam int WD_W   = 4;
  localparam int NREG   = 4;
  localparam logic [OPM_W-1:0] MODE_LIM = OPM_W'(MODE_CODES);
  localparam logic [WD_W-1:0]  WD_LIM   = WD_W'(WD_CODES);

  // Index 1..3: application bank and alternate bank
  logic [DATA_W-1:0] bank_app [1:NREG-1];
  logic [DATA_W-1:0] bank_alt [1:NREG-1];

  logic wr_en, fail, code_ok, app_wr;
  assign wr_en   = frame_end & frame_ok & ~frame_ro;
  assign fail    = frame_end & ~frame_ok;
  assign code_ok = (frame_data[OPM_W-1:0] < MODE_LIM) &&
                   (frame_data[OPM_W+WD_W-1:OPM_W] < WD_LIM);
  assign app_wr  = is_app_mode(op_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < NREG; i++) begin
        bank_app[i] <= '0;
        bank_alt[i] <= '0;
      end
      mode_q       <= '0;
      wd_serve     <= 1'b0;
      spi_fail_irq <= 1'b0;
      rst_req      <= 1'b0;
    end else begin
      wd_serve     <= 1'b0;
      spi_fail_irq <= 1'b0;
      rst_req      <= 1'b0;
      if (wr_en) begin
        if (frame_addr == 2'd0) begin
          if (code_ok) begin
            mode_q   <= frame_data;
            wd_serve <= 1'b1;
          end else begin
            rst_req  <= 1'b1;
          end
        end else begin
          for (int i = 1; i < NREG; i++) begin
            if (frame_addr == 2'(i)) begin
              if (app_wr) bank_app[i] <= frame_data;
              else        bank_alt[i] <= frame_data;
            end
          end
        end
      end
      if (fail) begin
        if (is_boot_mode(op_mode))           rst_req      <= 1'b1;
        else if (bank_app[1][IE_SPI_BIT])    spi_fail_irq <= 1'b1;
      end
    end
  end

  always_comb begin
    case (hdr_addr)
      2'd0:    rd_data = hdr_rrs ? sys_diag : sys_status;
      2'd1:    rd_data = !hdr_rrs ? bank_app[1] :
                         (is_app_mode(op_mode) ? irq_flags : bank_alt[1]);
      2'd2:    rd_data = hdr_rrs ? bank_alt[2] : bank_app[2];
      default: rd_data = hdr_rrs ? bank_alt[3] : bank_app[3];
    endcase
  end

  assign int_en_q  = bank_app[1];
  assign sys_cfg_q = bank_app[2];
  assign phy_q     = bank_app[3];
  assign special_q = bank_alt[1];
  assign gp0_q     = bank_alt[2];
  assign gp1_q     = bank_alt[3];
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_frame_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_CODES  = 5,
  parameter int WD_CODES    = 12,
  parameter int IE_SPI_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  input  logic [2:0]        op_mode,
  input  logic [DATA_W-1:0] sys_status,
  input  logic [DATA_W-1:0] sys_diag,
  input  logic [DATA_W-1:0] irq_flags,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] int_en_q,
  output logic [DATA_W-1:0] sys_cfg_q,
  output logic [DATA_W-1:0] phy_q,
  output logic [DATA_W-1:0] special_q,
  output logic [DATA_W-1:0] gp0_q,
  output logic [DATA_W-1:0] gp1_q,
  output logic              wd_serve,
  output logic              spi_fail_irq,
  output logic              rst_req
);
  logic [2:0]        pins_s;
  logic [1:0]        hdr_addr, frame_addr;
  logic              hdr_rrs, frame_end, frame_ok, frame_ro;
  logic [DATA_W-1:0] frame_data, rd_data;

  // bit 2: sclk, bit 1: csn (idles high), bit 0: mosi
  spi_frame_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, csn, mosi}),
    .q   (pins_s)
  );

  spi_frame_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (pins_s[2]),
    .csn_s      (pins_s[1]),
    .mosi_s     (pins_s[0]),
    .op_mode    (op_mode),
    .rd_data    (rd_data),
    .hdr_addr   (hdr_addr),
    .hdr_rrs    (hdr_rrs),
    .frame_end  (frame_end),
    .frame_ok   (frame_ok),
    .frame_addr (frame_addr),
    .frame_ro   (frame_ro),
    .frame_data (frame_data),
    .miso       (miso)
  );

  spi_frame_regs #(
    .DATA_W(DATA_W), .MODE_CODES(MODE_CODES),
    .WD_CODES(WD_CODES), .IE_SPI_BIT(IE_SPI_BIT)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .op_mode      (op_mode),
    .hdr_addr     (hdr_addr),
    .hdr_rrs      (hdr_rrs),
    .frame_end    (frame_end),
    .frame_ok     (frame_ok),
    .frame_addr   (frame_addr),
    .frame_ro     (frame_ro),
    .frame_data   (frame_data),
    .sys_status   (sys_status),
    .sys_diag     (sys_diag),
    .irq_flags    (irq_flags),
    .rd_data      (rd_data),
    .mode_q       (mode_q),
    .int_en_q     (int_en_q),
    .sys_cfg_q    (sys_cfg_q),
    .phy_q        (phy_q),
    .special_q    (special_q),
    .gp0_q        (gp0_q),
    .gp1_q        (gp1_q),
    .wd_serve     (wd_serve),
    .spi_fail_irq (spi_fail_irq),
    .rst_req      (rst_req)
  );
endmodule

// File: rtl/spi_frame_ctl_chk.sv
module spi_frame_ctl_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_mode,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] int_en_q,
  input logic              wd_serve,
  input logic              spi_fail_irq,
  input logic              rst_req
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!wd_serve && !spi_fail_irq && !rst_req)); // R1

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    spi_fail_irq |-> $past(int_en_q[0])); // R5

  AST_IRQ_NOT_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
    spi_fail_irq |-> ($past(op_mode) > 3'd1)); // R6

  AST_IRQ_RESET_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(spi_fail_irq && rst_req)); // R6

  AST_WD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wd_serve |=> !wd_serve); // R11

  AST_MODE_WRITE_SERVES: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> wd_serve); // R11

  AST_MODE_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (mode_q[2:0] < 3'd5) && (mode_q[6:3] < 4'd12)); // R12
endmodule

bind spi_frame_ctl spi_frame_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_mode      (op_mode),
  .mode_q       (mode_q),
  .int_en_q     (int_en_q),
  .wd_serve     (wd_serve),
  .spi_fail_irq (spi_fail_irq),
  .rst_req      (rst_req)
);

// File: tb/spi_frame_ctl_tb.sv
module spi_frame_ctl_tb;
  localparam int HALF = 6;
  localparam logic [11:0] STATUS = 12'hA51;
  localparam logic [11:0] DIAG   = 12'h3C7;
  localparam logic [11:0] FLAGS  = 12'h0E2;

  // {op_mode, frame word, expected reply data}
  localparam logic [30:0] VEC [0:16] = '{
    {3'd2, 16'h4001, 12'h000},  // R7 int_en <= 001
    {3'd2, 16'h5000, 12'h001},  // R9 int_en feedback
    {3'd2, 16'h7000, 12'h0E2},  // R9 irq flags in normal
    {3'd2, 16'h85A5, 12'h000},  // R7 sys_cfg
    {3'd2, 16'hC3C3, 12'h000},  // R7 phy
    {3'd4, 16'h8123, 12'h5A5},  // R7 gp0 in flash
    {3'd4, 16'hC456, 12'h3C3},  // R7 gp1 in flash
    {3'd4, 16'h4789, 12'h001},  // R7 special in flash
    {3'd4, 16'h7000, 12'h789},  // R9 special feedback
    {3'd3, 16'h7000, 12'h0E2},  // R9 irq flags in standby
    {3'd2, 16'hB000, 12'h123},  // R9 gp0 feedback
    {3'd2, 16'hF000, 12'h456},  // R9 gp1 feedback
    {3'd2, 16'h1000, 12'hA51},  // R8 status
    {3'd0, 16'h3000, 12'h3C7},  // R8 diag
    {3'd2, 16'hDFFF, 12'h3C3},  // R3 read-only, data ignored
    {3'd2, 16'hD000, 12'h3C3},  // R3 phy unchanged
    {3'd2, 16'h002B, 12'hA51}   // R11 mode op 3, wd 5
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [2:0] op_mode = 3'd2;
  logic [11:0] mode_q, int_en_q, sys_cfg_q, phy_q, special_q, gp0_q, gp1_q;
  logic wd_serve, spi_fail_irq, rst_req;
  int checks = 0, errors = 0;
  int wd_cnt = 0, irq_cnt = 0, rst_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_frame_ctl u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .mosi(mosi), .miso(miso),
    .op_mode(op_mode), .sys_status(STATUS), .sys_diag(DIAG), .irq_flags(FLAGS),
    .mode_q(mode_q), .int_en_q(int_en_q), .sys_cfg_q(sys_cfg_q), .phy_q(phy_q),
    .special_q(special_q), .gp0_q(gp0_q), .gp1_q(gp1_q),
    .wd_serve(wd_serve), .spi_fail_irq(spi_fail_irq), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    if (rst) begin
      wd_cnt <= 0; irq_cnt <= 0; rst_cnt <= 0;
    end else begin
      wd_cnt  <= wd_cnt + int'(wd_serve);
      irq_cnt <= irq_cnt + int'(spi_fail_irq);
      rst_cnt <= rst_cnt + int'(rst_req);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] rx);
    rx = '0;
    csn = 1'b0;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      wclk(HALF);
      if (i < 16) rx[15-i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    csn = 1'b1;
    wclk(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    int w0, i0, r0;
    wclk(5);
    // R1 reset state
    chk("R1 regs", {mode_q, int_en_q, sys_cfg_q}, 32'h0);
    chk("R1 regs2", {phy_q, special_q, gp0_q, gp1_q} == '0, 32'h1);
    chk("R1 pulses", {miso, wd_serve, spi_fail_irq, rst_req}, 32'h0);
    rst = 1'b0;
    wclk(5);

    for (int v = 0; v < 17; v++) begin
      op_mode = VEC[v][30:28];
      wclk(2);
      xfer(VEC[v][27:12], 16, rx);
      chk("R8/R9 reply data", rx[11:0], VEC[v][11:0]);
      chk("R10 reply lead", rx[15:12], {1'b0, VEC[v][30:28]});
    end
    chk("R2 sys_cfg", sys_cfg_q, 12'h5A5);
    chk("R7 phy", phy_q, 12'h3C3);
    chk("R7 alt bank", {gp0_q, gp1_q}, {8'h0, 12'h123, 12'h456});
    chk("R7 special", special_q, 12'h789);
    chk("R11 mode", mode_q, 12'h02B);
    chk("R11 wd count", wd_cnt, 1);
    chk("R5 no spurious irq/rst", irq_cnt + rst_cnt, 0);

    // R4/R5 15 clocks in normal, irq enabled
    op_mode = 3'd2; wclk(2);
    i0 = irq_cnt; r0 = rst_cnt;
    xfer(16'h8FFF, 15, rx);
    chk("R4 15 clk no write", sys_cfg_q, 12'h5A5);
    chk("R5 irq on 15", irq_cnt - i0, 1);
    chk("R5 no rst", rst_cnt - r0, 0);
    i0 = irq_cnt;
    xfer(16'h8FFF, 17, rx);
    chk("R4 17 clk no write", sys_cfg_q, 12'h5A5);
    chk("R5 irq on 17", irq_cnt - i0, 1);

    // R6 boot modes
    op_mode = 3'd0; wclk(2);
    i0 = irq_cnt; r0 = rst_cnt;
    xfer(16'h8FFF, 15, rx);
    chk("R6 gp0 kept", gp0_q, 12'h123);
    chk("R6 rst startup", rst_cnt - r0, 1);
    chk("R6 no irq", irq_cnt - i0, 0);
    op_mode = 3'd1; wclk(2);
    r0 = rst_cnt;
    xfer(16'h0000, 0, rx);
    chk("R6 rst restart 0 clk", rst_cnt - r0, 1);
    chk("R4 0 clk mode kept", mode_q, 12'h02B);

    // R5 interrupt disabled in standby
    op_mode = 3'd3; wclk(2);
    xfer(16'h4000, 16, rx);
    chk("R7 int_en cleared", int_en_q, 12'h000);
    i0 = irq_cnt; r0 = rst_cnt;
    xfer(16'hC111, 15, rx);
    chk("R5 masked irq", irq_cnt - i0, 0);
    chk("R5 masked no rst", rst_cnt - r0, 0);
    chk("R4 phy kept", phy_q, 12'h3C3);

    // R12 illegal codes
    op_mode = 3'd2; wclk(2);
    w0 = wd_cnt; r0 = rst_cnt;
    xfer(16'h0006, 16, rx);
    chk("R12 bad mode rst", rst_cnt - r0, 1);
    chk("R12 bad mode kept", mode_q, 12'h02B);
    xfer(16'h006A, 16, rx);
    chk("R12 bad wd rst", rst_cnt - r0, 2);
    chk("R12 no wd", wd_cnt - w0, 0);

    // R3/R11 read-only mode access does not serve
    xfer(16'h1001, 16, rx);
    chk("R3 ro no serve", wd_cnt - w0, 0);
    chk("R3 ro mode kept", mode_q, 12'h02B);
    xfer(16'h005C, 16, rx);
    chk("R11 mode updated", mode_q, 12'h05C);
    chk("R11 one serve", wd_cnt - w0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule